// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block is the receive half of an asynchronous serial port. A single-cycle enable, `tick_i`, pulses at sixteen times the bit rate (the count is a parameter). The block watches the serial line for a falling edge. It checks that the start bit is still low half a bit later. It then samples each data bit, an optional parity bit and the first stop bit at the centre of its bit time. Data arrives least significant bit first.

The character format sits in a small control register, written by a one-cycle load strobe. The format has four fields: a word length of five to eight bits, a parity disable, a parity sense and a one-or-two stop bit choice. At the centre of the first stop bit the character moves into a holding register. Any unused upper bits of that register are zero, and the overrun flag is decided in the same cycle. One tick later, data-available, parity-error and framing-error become valid. Software-side logic clears data-available with an active-low strobe. Two active-low enables stand in for the status and data bus drivers: when an enable is high, the matching outputs read zero and their drive indicators are low.

Top module: `uart_rx_core`

## Requirements
- R1: A low level seen on a tick while idle starts a bit timer. The start bit is accepted only if the line is still low 8 ticks later. Otherwise the receiver drops back to idle with no flag change, so a low pulse shorter than half a bit produces no character.
- R2: Data bits arrive least significant bit first, each sampled 16 ticks after the previous sample. The word length code selects the bit count: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R3: When parity is enabled (par_off = 0), one parity bit follows the data. par_even = 1 expects an even count of ones over data plus parity, and par_even = 0 expects an odd count. A mismatch sets the parity error. With parity disabled no parity bit is taken and the parity error reads 0 for every character.
- R4: The holding register changes only at the centre of the first stop bit. Through the data and parity bits it keeps the previous character.
- R5: Holding register bits at and above the word length are loaded as 0.
- R6: At the load, the overrun flag takes the value data-available has at that moment. It is 1 if the last character was not yet cleared, and 0 otherwise.
- R7: Data-available rises, and the parity and framing errors take the new character's values, exactly one tick after the holding register load.
- R8: A low level on da_clr_n_i clears data-available. A set in the same cycle wins.
- R9: A low first stop bit sets the framing error. After any character, the receiver will not arm for a new start edge until it has seen the line high on a tick, so a held-low line yields no further characters.
- R10: With stat_oe_n_i high, da_o, oe_o, pe_o and fe_o read 0 and stat_drv_o is 0. With data_oe_n_i high, rx_data_o reads 0 and data_drv_o is 0.
- R11: After reset the holding register and all four flags are 0, and the format is 8 bits, parity disabled, odd sense, one stop bit.
- R12: Format inputs take effect only on a ctl_load_i pulse. Changing them without the pulse leaves reception unchanged.
- R13: With two stop bits selected, the receiver does not re-arm until after the centre of the second stop bit. Back-to-back frames with two stop bits are each received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| ctl_load_i | input | 1 | Strobe that captures the format inputs |
| wlen_i | input | 2 | Word length code (00=5 ... 11=8 bits) |
| par_off_i | input | 1 | 1 disables parity |
| par_even_i | input | 1 | 1 selects even parity, 0 odd |
| stop2_i | input | 1 | 1 selects two stop bits |
| da_clr_n_i | input | 1 | Active-low clear of data-available |
| stat_oe_n_i | input | 1 | Active-low enable of the status outputs |
| data_oe_n_i | input | 1 | Active-low enable of the data outputs |
| rx_data_o | output | 8 | Holding register, gated by data_oe_n_i |
| data_drv_o | output | 1 | Data outputs are driven |
| da_o | output | 1 | Data available |
| oe_o | output | 1 | Overrun error |
| pe_o | output | 1 | Parity error |
| fe_o | output | 1 | Framing error |
| stat_drv_o | output | 1 | Status outputs are driven |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and a two-stage input synchronizer. It pulses the tick every fourth clock, so one bit lasts 64 clocks. Because a tick spans several clocks, the one-tick gap between the holding register load and the rise of data-available shows as a distinct four-clock offset. It cannot be confused with a single register stage. A bit time this short also lets all four word lengths, both parity senses, glitches, overruns and back-to-back two-stop frames run in a few tens of thousands of cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    parameter int unsigned RX_DATA_W   = 8;
    parameter int unsigned RX_MIN_BITS = 5;
    parameter int unsigned RX_WLEN_W   = 2;
    localparam int unsigned RX_IDX_W   = $clog2(RX_DATA_W);

    typedef enum logic [2:0] {
        S_WAITHI,
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_FLAG,
        S_HOLD2
    } rx_state_e;

    typedef struct packed {
        logic [RX_WLEN_W-1:0] wlen;
        logic                 par_off;
        logic                 par_even;
        logic                 stop2;
    } rx_fmt_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d = din_i;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], din_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fmt_reg.sv
module uart_rx_fmt_reg
    import uart_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_i,
    input  rx_fmt_t fmt_i,
    output rx_fmt_t fmt_o
);
    rx_fmt_t fmt_d, fmt_q;

    always_comb begin
        fmt_d = fmt_q;
        if (load_i) fmt_d = fmt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q.wlen     <= '1;
            fmt_q.par_off  <= 1'b1;
            fmt_q.par_even <= 1'b0;
            fmt_q.stop2    <= 1'b0;
        end else begin
            fmt_q <= fmt_d;
        end
    end

    assign fmt_o = fmt_q;
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rx_i,
    input  rx_fmt_t              fmt_i,
    output logic                 load_o,
    output logic [RX_DATA_W-1:0] data_o,
    output logic                 valid_o,
    output logic                 pe_o,
    output logic                 fe_o
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     cnt;
        logic [RX_IDX_W-1:0]  bitn;
        logic [RX_DATA_W-1:0] shreg;
        logic                 pe;
        logic                 fe;
    } frame_t;

    frame_t q, d;
    logic [RX_IDX_W-1:0] last_idx;
    logic                par_bad;

    assign last_idx = RX_IDX_W'(RX_MIN_BITS - 1) + RX_IDX_W'(fmt_i.wlen);
    assign par_bad  = ((^q.shreg) ^ rx_i) != !fmt_i.par_even;

    always_comb begin
        d       = q;
        load_o  = 1'b0;
        valid_o = 1'b0;
        unique case (q.state)
            S_WAITHI: if (tick_i && rx_i) d.state = S_IDLE;
            S_IDLE: if (tick_i && !rx_i) begin
                d.state = S_START;
                d.cnt   = '0;
            end
            S_START: if (tick_i) begin
                if (q.cnt == MID) begin
                    if (rx_i) begin
                        d.state = S_IDLE;
                    end else begin
                        d.state = S_DATA;
                        d.cnt   = '0;
                        d.bitn  = '0;
                        d.shreg = '0;
                        d.pe    = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: if (tick_i) begin
                if (q.cnt == LAST) begin
                    d.shreg[q.bitn] = rx_i;
                    d.cnt           = '0;
                    if (q.bitn == last_idx)
                        d.state = fmt_i.par_off ? S_STOP : S_PAR;
                    else
                        d.bitn = q.bitn + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_PAR: if (tick_i) begin
                if (q.cnt == LAST) begin
                    d.pe    = par_bad;
                    d.cnt   = '0;
                    d.state = S_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_STOP: if (tick_i) begin
                if (q.cnt == LAST) begin
                    load_o  = 1'b1;
                    d.fe    = !rx_i;
                    d.cnt   = '0;
                    d.state = S_FLAG;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_FLAG: if (tick_i) begin
                valid_o = 1'b1;
                d.cnt   = '0;
                d.state = fmt_i.stop2 ? S_HOLD2 : S_WAITHI;
            end
            S_HOLD2: if (tick_i) begin
                if (q.cnt == LAST) d.state = S_WAITHI;
                else               d.cnt   = q.cnt + 1'b1;
            end
            default: d.state = S_WAITHI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_WAITHI;
            q.cnt   <= '0;
            q.bitn  <= '0;
            q.shreg <= '0;
            q.pe    <= 1'b0;
            q.fe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.shreg;
    assign pe_o   = q.pe;
    assign fe_o   = q.fe;
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [RX_DATA_W-1:0] data_i,
    input  logic                 valid_i,
    input  logic                 pe_i,
    input  logic                 fe_i,
    input  logic                 da_clr_n_i,
    output logic [RX_DATA_W-1:0] hold_o,
    output logic                 da_o,
    output logic                 oe_o,
    output logic                 pe_o,
    output logic                 fe_o
);
    typedef struct packed {
        logic [RX_DATA_W-1:0] hold;
        logic                 da;
        logic                 oe;
        logic                 pe;
        logic                 fe;
    } flags_t;

    flags_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.hold = data_i;
            d.oe   = q.da;
        end
        if (!da_clr_n_i) d.da = 1'b0;
        if (valid_i) begin
            d.da = 1'b1;
            d.pe = pe_i;
            d.fe = fe_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_o = q.hold;
    assign da_o   = q.da;
    assign oe_o   = q.oe;
    assign pe_o   = q.pe;
    assign fe_o   = q.fe;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rxd_i,
    input  logic                 ctl_load_i,
    input  logic [1:0]           wlen_i,
    input  logic                 par_off_i,
    input  logic                 par_even_i,
    input  logic                 stop2_i,
    input  logic                 da_clr_n_i,
    input  logic                 stat_oe_n_i,
    input  logic                 data_oe_n_i,
    output logic [RX_DATA_W-1:0] rx_data_o,
    output logic                 data_drv_o,
    output logic                 da_o,
    output logic                 oe_o,
    output logic                 pe_o,
    output logic                 fe_o,
    output logic                 stat_drv_o
);
    rx_fmt_t              fmt_in_w, fmt_w;
    logic                 rx_w;
    logic                 load_w, valid_w, fpe_w, ffe_w;
    logic [RX_DATA_W-1:0] fdata_w, hold_w;
    logic                 da_w, oe_w, pe_w, fe_w;

    assign fmt_in_w = '{wlen: wlen_i, par_off: par_off_i,
                        par_even: par_even_i, stop2: stop2_i};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din_i(rxd_i), .dout_o(rx_w)
    );

    uart_rx_fmt_reg i_fmt (
        .clk(clk), .rst_n(rst_n), .load_i(ctl_load_i),
        .fmt_i(fmt_in_w), .fmt_o(fmt_w)
    );

    uart_rx_frame #(.OVS(OVS)) i_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_w),
        .fmt_i(fmt_w), .load_o(load_w), .data_o(fdata_w),
        .valid_o(valid_w), .pe_o(fpe_w), .fe_o(ffe_w)
    );

    uart_rx_flags i_flags (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .data_i(fdata_w),
        .valid_i(valid_w), .pe_i(fpe_w), .fe_i(ffe_w),
        .da_clr_n_i(da_clr_n_i), .hold_o(hold_w), .da_o(da_w),
        .oe_o(oe_w), .pe_o(pe_w), .fe_o(fe_w)
    );

    always_comb begin
        stat_drv_o = !stat_oe_n_i;
        data_drv_o = !data_oe_n_i;
        rx_data_o  = data_drv_o ? hold_w : '0;
        da_o       = stat_drv_o & da_w;
        oe_o       = stat_drv_o & oe_w;
        pe_o       = stat_drv_o & pe_w;
        fe_o       = stat_drv_o & fe_w;
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
    import uart_rx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load,
    input logic                 valid,
    input logic                 da,
    input logic                 oe,
    input logic [RX_DATA_W-1:0] hold,
    input logic [RX_WLEN_W-1:0] wlen,
    input logic                 da_clr_n,
    input logic                 data_oe_n,
    input logic [RX_DATA_W-1:0] rx_data
);
    logic [RX_DATA_W-1:0] fill_mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fill_mask_q <= '1;
        else if (load) fill_mask_q <= RX_DATA_W'((1 << (RX_MIN_BITS + int'(wlen))) - 1);
    end

    p_hold_only_at_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold));

    p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((hold & ~fill_mask_q) == '0));

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && da) |=> oe);

    p_overrun_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !da) |=> !oe);

    p_da_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(da) |-> $past(valid));

    p_valid_not_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !load);

    p_da_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!da_clr_n && !valid) |=> !da);

    p_data_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_n |-> (rx_data == '0));
endmodule

bind uart_rx_core uart_rx_chk i_uart_rx_chk (
    .clk(clk), .rst_n(rst_n), .load(load_w), .valid(valid_w),
    .da(da_w), .oe(oe_w), .hold(hold_w), .wlen(fmt_w.wlen),
    .da_clr_n(da_clr_n_i), .data_oe_n(data_oe_n_i), .rx_data(rx_data_o)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       rxd_i = 1'b1;
    logic       ctl_load_i = 1'b0;
    logic [1:0] wlen_i = 2'b11;
    logic       par_off_i = 1'b1, par_even_i = 1'b0, stop2_i = 1'b0;
    logic       da_clr_n_i = 1'b1, stat_oe_n_i = 1'b0, data_oe_n_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       data_drv_o, da_o, oe_o, pe_o, fe_o, stat_drv_o;

    int vecs = 0;
    int miss = 0;
    int tdiv = 0;
    int wdog = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_i <= (tdiv == TICK_DIV - 1);
    end

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rxd_i(rxd_i),
        .ctl_load_i(ctl_load_i), .wlen_i(wlen_i), .par_off_i(par_off_i),
        .par_even_i(par_even_i), .stop2_i(stop2_i), .da_clr_n_i(da_clr_n_i),
        .stat_oe_n_i(stat_oe_n_i), .data_oe_n_i(data_oe_n_i),
        .rx_data_o(rx_data_o), .data_drv_o(data_drv_o), .da_o(da_o),
        .oe_o(oe_o), .pe_o(pe_o), .fe_o(fe_o), .stat_drv_o(stat_drv_o)
    );

    always @(posedge clk) begin
        wdog <= wdog + 1;
        if (wdog > 150000) begin
            miss++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wdog);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] wl, input bit poff, input bit even, input bit s2);
        wlen_i = wl; par_off_i = poff; par_even_i = even; stop2_i = s2;
        ctl_load_i = 1'b1;
        @(negedge clk);
        ctl_load_i = 1'b0;
    endtask

    task automatic clear_da();
        da_clr_n_i = 1'b0;
        @(negedge clk);
        da_clr_n_i = 1'b1;
    endtask

    task automatic send_bit(input bit v);
        rxd_i = v;
        idle(BIT_CLK);
    endtask

    task automatic send_head(input logic [7:0] d, input int nb, input bit pen,
                             input bit even, input bit badpar);
        bit p;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        p = p ^ !even ^ badpar;
        if (pen) send_bit(p);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit even, input bit badpar, input bit stopv,
                              input int nstop);
        send_head(d, nb, pen, even, badpar);
        send_bit(stopv);
        for (int i = 1; i < nstop; i++) send_bit(1'b1);
        rxd_i = 1'b1;
        idle(16);
    endtask

    task automatic t_reset();
        chk("R11 data after reset", rx_data_o, 0);
        chk("R11 flags after reset", {da_o, oe_o, pe_o, fe_o}, 0);
        send_frame(8'hA5, 8, 0, 0, 0, 1, 1);
        chk("R11 default 8-bit no-parity data", rx_data_o, 8'hA5);
        chk("R11 default format flags", {da_o, oe_o, pe_o, fe_o}, 4'b1000);
        clear_da();
    endtask

    task automatic t_word_lengths();
        for (int w = 0; w < 4; w++) begin
            int nb = 5 + w;
            set_fmt(2'(w), 1'b1, 1'b0, 1'b0);
            send_frame(8'hFF, nb, 0, 0, 0, 1, 1);
            chk("R5 zero fill of upper bits", rx_data_o, (32'd1 << nb) - 1);
            clear_da();
            send_frame(8'h96, nb, 0, 0, 0, 1, 1);
            chk("R2 lsb-first pattern", rx_data_o, 32'h96 & ((32'd1 << nb) - 1));
            clear_da();
        end
    endtask

    task automatic t_parity();
        set_fmt(2'b11, 1'b0, 1'b1, 1'b0);
        send_frame(8'h37, 8, 1, 1, 0, 1, 1);
        chk("R3 even parity correct", {da_o, pe_o, rx_data_o}, {2'b10, 8'h37});
        clear_da();
        send_frame(8'h37, 8, 1, 1, 1, 1, 1);
        chk("R3 even parity bad", {da_o, pe_o}, 2'b11);
        clear_da();
        set_fmt(2'b10, 1'b0, 1'b0, 1'b0);
        send_frame(8'h41, 7, 1, 0, 0, 1, 1);
        chk("R3 odd parity correct", {da_o, pe_o, rx_data_o}, {2'b10, 8'h41});
        clear_da();
        send_frame(8'h41, 7, 1, 0, 1, 1, 1);
        chk("R3 odd parity bad", pe_o, 1);
        clear_da();
        set_fmt(2'b11, 1'b1, 1'b1, 1'b0);
        send_frame(8'h01, 8, 0, 0, 0, 1, 1);
        chk("R3 parity disabled no error", {pe_o, rx_data_o}, {1'b0, 8'h01});
        clear_da();
    endtask

    task automatic t_glitch();
        logic [7:0] prev = rx_data_o;
        rxd_i = 1'b0;
        idle(6 * TICK_DIV);
        rxd_i = 1'b1;
        idle(4 * BIT_CLK);
        chk("R1 short low pulse rejected da", da_o, 0);
        chk("R1 short low pulse data unchanged", rx_data_o, prev);
        send_frame(8'hC3, 8, 0, 0, 0, 1, 1);
        chk("R1 valid frame after glitch", {da_o, rx_data_o}, {1'b1, 8'hC3});
        clear_da();
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 8, 0, 0, 0, 1, 1);
        send_frame(8'h22, 8, 0, 0, 0, 1, 1);
        chk("R6 overrun when da not cleared", {oe_o, rx_data_o}, {1'b1, 8'h22});
        clear_da();
        send_frame(8'h33, 8, 0, 0, 0, 1, 1);
        chk("R6 no overrun after clear", {oe_o, da_o}, 2'b01);
    endtask

    task automatic t_da_clear();
        chk("R8 da set before clear", da_o, 1);
        da_clr_n_i = 1'b0;
        @(negedge clk);
        da_clr_n_i = 1'b1;
        @(negedge clk);
        chk("R8 da cleared by strobe", da_o, 0);
        chk("R8 data kept after clear", rx_data_o, 8'h33);
    endtask

    task automatic t_framing();
        send_head(8'h5C, 8, 0, 0, 0);
        rxd_i = 1'b0;
        idle(BIT_CLK);
        chk("R9 framing error on low stop", {da_o, fe_o}, 2'b11);
        clear_da();
        idle(4 * BIT_CLK);
        chk("R9 held-low line gives no char", da_o, 0);
        rxd_i = 1'b1;
        idle(BIT_CLK);
        send_frame(8'h6D, 8, 0, 0, 0, 1, 1);
        chk("R9 recovery after line high", {da_o, fe_o, rx_data_o}, {2'b10, 8'h6D});
        clear_da();
    endtask

    task automatic t_enables();
        send_frame(8'hE7, 8, 0, 0, 0, 1, 1);
        stat_oe_n_i = 1'b1;
        data_oe_n_i = 1'b1;
        @(negedge clk);
        chk("R10 status gated", {stat_drv_o, da_o, oe_o, pe_o, fe_o}, 0);
        chk("R10 data gated", {data_drv_o, rx_data_o}, 0);
        stat_oe_n_i = 1'b0;
        data_oe_n_i = 1'b0;
        @(negedge clk);
        chk("R10 re-enabled", {stat_drv_o, data_drv_o, da_o, rx_data_o}, {3'b111, 8'hE7});
        clear_da();
    endtask

    task automatic t_ctl_hold();
        set_fmt(2'b11, 1'b1, 1'b0, 1'b0);
        wlen_i = 2'b00; par_off_i = 1'b0;
        send_frame(8'hF0, 8, 0, 0, 0, 1, 1);
        chk("R12 format unchanged without load", {pe_o, rx_data_o}, {1'b0, 8'hF0});
        clear_da();
        wlen_i = 2'b11; par_off_i = 1'b1;
    endtask

    task automatic t_flag_delay();
        int t_load = -1;
        int t_da   = -1;
        send_frame(8'h00, 8, 0, 0, 0, 1, 1);
        clear_da();
        send_head(8'h5A, 8, 0, 0, 0);
        chk("R4 hold unchanged before stop", rx_data_o, 8'h00);
        rxd_i = 1'b1;
        for (int i = 0; i < BIT_CLK; i++) begin
            @(negedge clk);
            if (t_load < 0 && rx_data_o == 8'h5A) t_load = i;
            if (t_da < 0 && da_o) t_da = i;
        end
        chk("R4 load near stop centre", (t_load > 28 && t_load < 44), 1);
        chk("R7 da one tick after load", t_da - t_load, TICK_DIV);
        clear_da();
    endtask

    task automatic t_stop2();
        set_fmt(2'b11, 1'b1, 1'b0, 1'b1);
        send_frame(8'h81, 8, 0, 0, 0, 1, 2);
        chk("R13 first two-stop frame", rx_data_o, 8'h81);
        clear_da();
        send_head(8'h3C, 8, 0, 0, 0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_frame(8'hA9, 8, 0, 0, 0, 1, 2);
        chk("R13 back-to-back two-stop frame", {oe_o, rx_data_o}, {1'b1, 8'hA9});
        clear_da();
        set_fmt(2'b11, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_word_lengths();
        t_parity();
        t_glitch();
        t_overrun();
        t_da_clear();
        t_framing();
        t_enables();
        t_ctl_hold();
        t_flag_delay();
        t_stop2();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule